// File: doc/BRIEF.md
# Flash Erase Command Controller

This block is the command state machine that sits on the device side of one NOR-style flash bank. It watches the host's 16-bit word writes and recognises the six-write chip erase sequence, along with a sector erase variant that shares its first five writes. Once an erase is accepted, the block steps through a modelled embedded erase. A chip erase first drives every cell to zero and then erases. A sector erase first opens a short window in which a suspend request is still accepted, and then erases. Each phase length is a parameter, so a bench or a system model can shorten it.

A status read made while an erase runs returns polling bits in place of array data. The host can poll for completion and tell the erase phases apart without a separate status register. Only a sector erase can be suspended and later resumed. A chip erase cannot be interrupted by any command, and only the hardware reset stops it. The memory array itself is stood in for by one representative word. That word holds a parameter value after reset, becomes 0000h when preprogramming ends, and becomes FFFFh when an erase completes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `busy` is 0, the bank is in read mode, and `rd_data` shows the array word, which equals the parameter `INIT_WORD`.
- R2: A chip erase starts on these six word writes, in order: AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, then 10h to 555h. Only the low 11 address bits and the low data byte are compared. `busy` reads 1 in the cycle after the clock edge that takes the sixth write.
- R3: A write that does not match the expected cycle returns the decoder to its first step without starting anything. A correct full sequence written afterwards still starts the erase.
- R4: A chip erase holds `busy` for exactly PRE_CYC + ERASE_CYC cycles. Bit 2 of the status stays constant across status reads during the first PRE_CYC cycles (preprogram). It flips on every status read during the last ERASE_CYC cycles (erase).
- R5: When an erase completes, `busy` falls and `rd_data` reads FFFFh.
- R6: While `busy` is 1, `rd_data` is a status word. Bit 7 is 0, and bit 6 takes opposite values on any two consecutive status reads (`rd_en` high).
- R7: While a chip erase runs, every write is ignored, including suspend (B0h). The busy time and the FFFFh result are unchanged.
- R8: Asserting `rst_n` low during an erase ends it at once. `busy` goes to 0 and `rd_data` returns to `INIT_WORD`.
- R9: If 30h, written to any address, is the sixth write, a sector erase starts. It stays busy for TSEA_CYC window cycles plus ERASE_CYC erase cycles, and bit 2 is constant during the window.
- R10: A B0h write inside the sector window suspends at the next clock edge, with `busy` 0. Suspended status reads show bit 7 = 1, a frozen bit 6 and a flipping bit 2.
- R11: A B0h write during the sector erase phase keeps `busy` at 1 for exactly SUSP_LAT more cycles, then suspends.
- R12: A 30h write while suspended resumes the erase. The erase finishes the cycles it had left and ends with FFFFh; after a window suspend it runs the full ERASE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Word write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; advances the status toggle bits |
| rd_data | output | 16 | Array word in read mode, status word otherwise |
| busy | output | 1 | High while an embedded erase is in progress |

## Verification
The decoder is driven with a write stream that breaks the sequence at several steps: wrong data at the setup step, a wrong address at the second unlock, and a wrong final command. The stream also sets upper address and data bits that must be ignored. Only the closing clean sequence may raise `busy`, which separates abort-to-start from a stalled or lenient decoder. The erase engine is tried with an uninterrupted chip erase and a chip erase hit by a suspend request, to tell the ignore rule apart from the sector path. It is also tried with sector erases suspended inside and after the window, and each of these pins down its own cycle count. The status samples taken during each run show the phase boundary through bit 2 and the polling rule through bits 7 and 6.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int DW     = 16;
   localparam int CMD_AW = 11;

   localparam logic [CMD_AW-1:0] A_KEY_HI = 11'h555;
   localparam logic [CMD_AW-1:0] A_KEY_LO = 11'h2AA;

   localparam logic [7:0] D_KEY_A  = 8'hAA;
   localparam logic [7:0] D_KEY_B  = 8'h55;
   localparam logic [7:0] D_ARM    = 8'h80;
   localparam logic [7:0] D_CHIP   = 8'h10;
   localparam logic [7:0] D_SECTOR = 8'h30;
   localparam logic [7:0] D_HOLD   = 8'hB0;
   localparam logic [7:0] D_RESUME = 8'h30;

   typedef enum logic [2:0] {
      ST_READ,
      ST_PREPGM,
      ST_WINDOW,
      ST_ERASE,
      ST_HOLD_WAIT,
      ST_HELD
   } eng_state_t;

   function automatic logic st_busy(eng_state_t s);
      return (s == ST_PREPGM) || (s == ST_WINDOW) || (s == ST_ERASE) || (s == ST_HOLD_WAIT);
   endfunction

   function automatic logic st_erasing(eng_state_t s);
      return (s == ST_ERASE) || (s == ST_HOLD_WAIT) || (s == ST_HELD);
   endfunction

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter bit STRICT_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic              start_chip,
   output logic              start_sector
);

   localparam int STEPS  = 6;
   localparam int STEP_W = $clog2(STEPS);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

   logic [STEP_W-1:0] step;
   logic [DW-1:0]     dview;
   logic [CMD_AW-1:0] alo;
   logic [CMD_AW-1:0] exp_a;
   logic [7:0]        exp_d;
   logic              hit;
   logic              take;

   generate
      if (STRICT_DATA) begin : g_full_word
         assign dview = wr_data;
      end else begin : g_low_byte
         assign dview = {8'h00, wr_data[7:0]};
      end
   endgenerate

   assign alo  = wr_addr[CMD_AW-1:0];
   assign take = enable && wr_en;

   always_comb begin
      unique case (step)
         3'd0:    begin exp_a = A_KEY_HI; exp_d = D_KEY_A; end
         3'd1:    begin exp_a = A_KEY_LO; exp_d = D_KEY_B; end
         3'd2:    begin exp_a = A_KEY_HI; exp_d = D_ARM;   end
         3'd3:    begin exp_a = A_KEY_HI; exp_d = D_KEY_A; end
         3'd4:    begin exp_a = A_KEY_LO; exp_d = D_KEY_B; end
         default: begin exp_a = A_KEY_HI; exp_d = D_CHIP;  end
      endcase
   end

   assign hit          = (alo == exp_a) && (dview == {8'h00, exp_d});
   assign start_chip   = take && (step == LAST) && hit;
   assign start_sector = take && (step == LAST) && (dview == {8'h00, D_SECTOR});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (!enable) begin
         step <= '0;
      end else if (wr_en) begin
         if (step == LAST || !hit) step <= '0;
         else                      step <= step + 1'b1;
      end
   end

   AST_STEP_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (start_chip || start_sector) |=> (step == '0)); // R3

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
   import flash_cmd_pkg::*;
#(
   parameter int          PRE_CYC   = 64,
   parameter int          ERASE_CYC = 256,
   parameter int          TSEA_CYC  = 32,
   parameter int          SUSP_LAT  = 8,
   parameter logic [15:0] INIT_WORD = 16'h5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_chip,
   input  logic          start_sector,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output eng_state_t    state,
   output logic [DW-1:0] word
);

   localparam int MAXC = (PRE_CYC > ERASE_CYC) ?
                         ((PRE_CYC > TSEA_CYC) ? PRE_CYC : TSEA_CYC) :
                         ((ERASE_CYC > TSEA_CYC) ? ERASE_CYC : TSEA_CYC);
   localparam int CW = $clog2(MAXC + 1);
   localparam int LW = $clog2(SUSP_LAT + 1);

   generate
      if (PRE_CYC < 1 || ERASE_CYC < 2 || TSEA_CYC < 1 || SUSP_LAT < 1) begin : g_bad_cycles
         $error("flash_erase_engine: phase lengths out of range");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [LW-1:0] lat;
   logic          chip_op;
   logic          hold_req;
   logic          resume_req;

   assign hold_req   = wr_en && (wr_data[7:0] == D_HOLD);
   assign resume_req = wr_en && (wr_data[7:0] == D_RESUME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_READ;
         cnt     <= '0;
         lat     <= '0;
         chip_op <= 1'b0;
         word    <= INIT_WORD;
      end else begin
         unique case (state)
            ST_READ: begin
               if (start_chip) begin
                  state   <= ST_PREPGM;
                  cnt     <= CW'(PRE_CYC - 1);
                  chip_op <= 1'b1;
               end else if (start_sector) begin
                  state   <= ST_WINDOW;
                  cnt     <= CW'(TSEA_CYC - 1);
                  chip_op <= 1'b0;
               end
            end
            ST_PREPGM: begin
               if (cnt == '0) begin
                  state <= ST_ERASE;
                  cnt   <= CW'(ERASE_CYC - 1);
                  word  <= '0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WINDOW: begin
               if (hold_req) begin
                  state <= ST_HELD;
                  cnt   <= CW'(ERASE_CYC - 1);
               end else if (cnt == '0) begin
                  state <= ST_ERASE;
                  cnt   <= CW'(ERASE_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_ERASE: begin
               if (cnt == '0) begin
                  state <= ST_READ;
                  word  <= '1;
               end else if (!chip_op && hold_req) begin
                  state <= ST_HOLD_WAIT;
                  lat   <= LW'(SUSP_LAT - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD_WAIT: begin
               if (lat == '0) state <= ST_HELD;
               else           lat   <= lat - 1'b1;
            end
            ST_HELD: begin
               if (resume_req) state <= ST_ERASE;
            end
            default: state <= ST_READ;
         endcase
      end
   end

   AST_CHIP_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_op && state != ST_READ) |-> (state != ST_HOLD_WAIT && state != ST_HELD)); // R7

   AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WINDOW && wr_en && wr_data[7:0] == D_HOLD) |=> (state == ST_HELD)); // R10

   AST_HOLD_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD_WAIT) |=> (state == ST_HOLD_WAIT || state == ST_HELD)); // R11

   AST_RESUME_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && wr_en && wr_data[7:0] == D_RESUME) |=> (state == ST_ERASE)); // R12

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_cmd_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  eng_state_t    state,
   input  logic [DW-1:0] word,
   output logic [DW-1:0] rd_data
);

   logic tog6;
   logic tog2;
   logic busy_now;

   assign busy_now = st_busy(state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else if (rd_en) begin
         if (busy_now)          tog6 <= ~tog6;
         if (st_erasing(state)) tog2 <= ~tog2;
      end
   end

   always_comb begin
      if (state == ST_READ) begin
         rd_data = word;
      end else begin
         rd_data    = '0;
         rd_data[7] = (state == ST_HELD);
         rd_data[6] = tog6;
         rd_data[2] = tog2;
      end
   end

   AST_DQ7_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_now && rd_en) |-> !rd_data[7]); // R6

   AST_DQ6_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_now && rd_en && $past(busy_now && rd_en)) |-> (rd_data[6] != $past(rd_data[6]))); // R6

   AST_DONE_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_now) && state == ST_READ) |-> (rd_data == 16'hFFFF)); // R5

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter bit          STRICT_DATA = 1'b0,
   parameter int          PRE_CYC     = 64,
   parameter int          ERASE_CYC   = 256,
   parameter int          TSEA_CYC    = 32,
   parameter int          SUSP_LAT    = 8,
   parameter logic [15:0] INIT_WORD   = 16'h5A5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              rd_en,
   output logic [15:0]       rd_data,
   output logic              busy
);

   generate
      if (ADDR_W < CMD_AW) begin : g_bad_addr
         $error("flash_cmd_ctrl: ADDR_W must cover the command address bits");
      end
   endgenerate

   eng_state_t    state;
   logic [DW-1:0] word;
   logic          start_chip;
   logic          start_sector;

   flash_seq_decode #(
      .ADDR_W      (ADDR_W),
      .STRICT_DATA (STRICT_DATA)
   ) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (state == ST_READ),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .start_chip   (start_chip),
      .start_sector (start_sector)
   );

   flash_erase_engine #(
      .PRE_CYC   (PRE_CYC),
      .ERASE_CYC (ERASE_CYC),
      .TSEA_CYC  (TSEA_CYC),
      .SUSP_LAT  (SUSP_LAT),
      .INIT_WORD (INIT_WORD)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_chip   (start_chip),
      .start_sector (start_sector),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .state        (state),
      .word         (word)
   );

   flash_status_gen u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .state   (state),
      .word    (word),
      .rd_data (rd_data)
   );

   assign busy = st_busy(state);

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_chip || start_sector) |=> busy); // R2

   AST_READ_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && state == ST_READ) |-> $stable(rd_data)); // R1

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

   localparam int          PRE  = 4;
   localparam int          ER   = 6;
   localparam int          WIN  = 5;
   localparam int          LAT  = 3;
   localparam logic [15:0] INIT = 16'h5A5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        busy;

   int vec = 0;
   int mis = 0;
   int cyc = 0;
   logic [15:0] smp [0:63];

   // {address, data, expected busy after the write}
   localparam int NV = 20;
   localparam logic [32:0] VT [0:NV-1] = '{
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h0055, 1'b0},
      {16'h0555, 16'h0081, 1'b0},
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h0055, 1'b0},
      {16'h0555, 16'h0080, 1'b0},
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AB, 16'h0055, 1'b0},
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h0055, 1'b0},
      {16'h0555, 16'h0080, 1'b0},
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h0055, 1'b0},
      {16'h0555, 16'h0020, 1'b0},
      {16'hF555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h3355, 1'b0},
      {16'h0555, 16'h0080, 1'b0},
      {16'h0555, 16'h00AA, 1'b0},
      {16'h02AA, 16'h0055, 1'b0},
      {16'h0555, 16'h0010, 1'b1}
   };

   flash_cmd_ctrl #(
      .ADDR_W    (16),
      .PRE_CYC   (PRE),
      .ERASE_CYC (ER),
      .TSEA_CYC  (WIN),
      .SUSP_LAT  (LAT),
      .INIT_WORD (INIT)
   ) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .busy    (busy)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         mis++;
         $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      vec++;
      if (!ok) begin
         mis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic seq6(input logic [15:0] a, input logic [15:0] d);
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0055);
      wr(16'h0555, 16'h0080);
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0055);
      wr(a, d);
   endtask

   // Samples every busy cycle with reads enabled; optionally writes B0h at sample number 'at'.
   task automatic run_busy(input bit inject, input int at, output int n);
      n = 0;
      rd_en = 1'b1;
      while (busy && n < 60) begin
         n++;
         smp[n] = rd_data;
         if (inject && n == at) begin
            wr_en   = 1'b1;
            wr_addr = 16'h0000;
            wr_data = 16'h00B0;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   // Status rules over samples 1..n: bit7 low, bit6 alternating, bit2 flipping only from sample 'flip_from'.
   task automatic chk_status(input int n, input int flip_from, input string tag);
      bit b7 = 1'b1;
      bit b6 = 1'b1;
      bit b2 = 1'b1;
      for (int i = 1; i <= n; i++) begin
         if (smp[i][7]) b7 = 1'b0;
         if (i < n) begin
            if (smp[i+1][6] == smp[i][6]) b6 = 1'b0;
            if ((smp[i+1][2] != smp[i][2]) != (i >= flip_from)) b2 = 1'b0;
         end
      end
      chk(b7, {tag, " R6 bit7 low while busy"}, b7, 1);
      chk(b6, {tag, " R6 bit6 alternates"}, b6, 1);
      chk(b2, {tag, " R4 bit2 phase rule"}, b2, 1);
   endtask

   initial begin
      int n;
      logic [15:0] r [0:2];

      do_reset();
      // R1: reset state
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(rd_data == INIT, "R1 array word after reset", rd_data, INIT);

      // R2 / R3: vector walk with broken sequences, then a clean chip erase
      for (int v = 0; v < NV; v++) begin
         wr(VT[v][32:17], VT[v][16:1]);
         chk(busy == VT[v][0], $sformatf("R3 R2 vector %0d busy", v), busy, VT[v][0]);
      end

      // R4 / R5 / R6: chip erase runs preprogram then erase
      run_busy(1'b0, 0, n);
      chk(n == PRE + ER, "R4 chip erase busy cycles", n, PRE + ER);
      chk_status(n, PRE + 1, "chip");
      chk(rd_data == 16'hFFFF, "R5 word after chip erase", rd_data, 16'hFFFF);

      // R7: suspend request during chip erase is ignored
      do_reset();
      seq6(16'h0555, 16'h0010);
      run_busy(1'b1, PRE + 2, n);
      chk(n == PRE + ER, "R7 chip erase length with B0h written", n, PRE + ER);
      chk(rd_data == 16'hFFFF, "R7 word after ignored suspend", rd_data, 16'hFFFF);

      // R8: hardware reset mid-erase
      do_reset();
      seq6(16'h0555, 16'h0010);
      repeat (PRE + 2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(busy == 1'b0, "R8 busy drops on reset", busy, 0);
      chk(rd_data == INIT, "R8 read mode after reset", rd_data, INIT);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: sector erase (30h to an arbitrary address)
      do_reset();
      seq6(16'h4321, 16'h0030);
      run_busy(1'b0, 0, n);
      chk(n == WIN + ER, "R9 sector erase busy cycles", n, WIN + ER);
      chk_status(n, WIN + 1, "sector");
      chk(rd_data == 16'hFFFF, "R9 word after sector erase", rd_data, 16'hFFFF);

      // R10: suspend inside the window takes effect at once
      do_reset();
      seq6(16'h4000, 16'h0030);
      run_busy(1'b1, 2, n);
      chk(n == 2, "R10 busy cycles with window suspend", n, 2);
      rd_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         r[k] = rd_data;
         @(negedge clk);
      end
      rd_en = 1'b0;
      chk(busy == 1'b0, "R10 busy while suspended", busy, 0);
      chk(r[0][7] && r[1][7] && r[2][7], "R10 bit7 high while suspended", {r[0][7], r[1][7], r[2][7]}, 3'b111);
      chk(r[0][6] == r[1][6] && r[1][6] == r[2][6], "R10 bit6 frozen", {r[0][6], r[1][6], r[2][6]}, {3{r[0][6]}});
      chk(r[0][2] != r[1][2] && r[1][2] != r[2][2], "R10 bit2 flips", {r[0][2], r[1][2], r[2][2]}, {r[0][2], ~r[0][2], r[0][2]});

      // R12: resume after a window suspend runs the full erase
      wr(16'h0000, 16'h0030);
      run_busy(1'b0, 0, n);
      chk(n == ER, "R12 erase cycles after window resume", n, ER);
      chk(rd_data == 16'hFFFF, "R12 word after resume", rd_data, 16'hFFFF);

      // R11: suspend after the window waits SUSP_LAT cycles
      do_reset();
      seq6(16'h4000, 16'h0030);
      run_busy(1'b1, WIN + 2, n);
      chk(n == WIN + 2 + LAT, "R11 busy cycles with late suspend", n, WIN + 2 + LAT);
      chk(rd_data[7] == 1'b1, "R11 suspended status bit7", rd_data[7], 1);
      wr(16'h0000, 16'h0030);
      run_busy(1'b0, 0, n);
      chk(n == ER - 1, "R12 remaining cycles after late resume", n, ER - 1);
      chk(rd_data == 16'hFFFF, "R12 word after late resume", rd_data, 16'hFFFF);

      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end

endmodule